// File: doc/BRIEF.md
# Threshold Interrupt Bid Arbiter

This block decides which of a multi-channel serial controller's interrupt sources is served next. Every channel contributes four sources: receive data, transmit data, receive status and break change. Two chip-level sources, a timer and an input-change detector, are attributed to channel 0. Each source that is requesting and enabled by its mask bit presents a 6-bit bid. A programmable threshold competes in the same contest. The interrupt output goes low only when the best enabled bid is strictly greater than the threshold. The contest is re-run on every clock and its result is held in an evaluation register.

The host captures that result into the current-interrupt register (CIR) with an acknowledge pulse or an update pulse. The CIR then steers the global holding-register accesses to the channel that raised the interrupt, and it supplies a global byte count and a global channel number. All pins are plain level or single-cycle strobe signals. No data stream crosses the block, so no valid/ready handshake or back-pressure exists. A global read or write strobe is forwarded in the same cycle as a one-hot strobe to the selected channel.

Top module: `irq_bid_arbiter`

## Requirements
- R1: A synchronous reset clears the mask, threshold and non-data level, drives `irq_n` high and sets `cir` to 8'hFF. Right after reset, no source can raise an interrupt.
- R2: A source whose mask bit is 0 never bids. Mask bit order is: receive data ch0..3 (bits 0-3), transmit data ch0..3 (4-7), receive status ch0..3 (8-11), break ch0..3 (12-15), timer (16), input change (17).
- R3: A bid is {level[2:0], type[2:0]} with type codes 1 receive data, 2 transmit data, 3 receive status, 4 break, 5 timer and 6 input change. The highest enabled bid wins. `irq_n` reflects the inputs sampled at the previous clock edge.
- R4: The interrupt is raised only when the winning bid is strictly greater than `cfg_thr`. A bid equal to the threshold raises nothing.
- R5: A capture taken while no bid beats the threshold loads `cir` with 8'hFF.
- R6: `cir` changes only in the cycle after `iack` or `cir_upd` is high. A capture loads `cir` = {field[2:0], type[2:0], channel[1:0]} from the evaluation register.
- R7: For data types, the field is the byte count: the receive fill count or the transmit free count. For non-data types, the field is the programmable level `cfg_evt_lvl`. `gl_cnt` always shows `cir[7:5]`.
- R8: A receive bid level equals its fill count (0 means no request). A transmit bid level is min(free count, 3), so its MSB is 0. With `cfg_thr` >= 6'b100000, a transmitter never wins, and any receiver with 4 or more bytes beats every transmitter.
- R9: Among equal bids, the lowest source index wins.
- R10: `gl_chan` shows `cir[1:0]`. `gl_rd` and `gl_wr` become one-hot strobes on `rxh_rd` and `txh_wr` for that channel. `gl_rx_data` returns that channel's receive holding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Loads mask, threshold and non-data level |
| cfg_mask | input | 18 | Per-source enable bits |
| cfg_thr | input | 6 | Interrupt threshold |
| cfg_evt_lvl | input | 3 | Level field of non-data bids |
| rx_cnt | input | 12 | Receive fill count, 3 bits per channel |
| tx_free | input | 12 | Transmit free count, 3 bits per channel |
| evt_req | input | 10 | Status[3:0], break[7:4], timer[8], input change[9] |
| iack | input | 1 | Interrupt acknowledge, captures the CIR |
| cir_upd | input | 1 | Update command, captures the CIR |
| irq_n | output | 1 | Interrupt request, active low |
| cir | output | 8 | Current-interrupt register |
| gl_cnt | output | 3 | Global byte count |
| gl_chan | output | 2 | Global interrupting channel |
| gl_rd | input | 1 | Global receive holding read strobe |
| gl_wr | input | 1 | Global transmit holding write strobe |
| rxh_rd | output | 4 | Per-channel receive holding read strobes |
| txh_wr | output | 4 | Per-channel transmit holding write strobes |
| rx_hold | input | 32 | Receive holding bytes, 8 bits per channel |
| gl_rx_data | output | 8 | Receive holding byte of the captured channel |

## Verification
A single receiver with a nonzero count checks the basic winner path and the byte-count field. The same receiver, masked out, shows that the mask gates bidding. A bid set exactly at the threshold and then one step above it separates a strict comparison from a non-strict one. Two receivers with identical counts expose the tie order. A full transmitter under a high threshold, joined later by a receiver with four bytes, separates the transmit level cap from the threshold. Non-data sources at a raised programmable level check the field substitution. Changing the winner without a capture confirms that the CIR holds its value. A behavioural model compares every output on every clock.

// File: rtl/irq_bid_pkg.sv
package irq_bid_pkg;
  localparam int LVLW = 3;
  localparam int TYPW = 3;
  localparam int BIDW = LVLW + TYPW;

  localparam logic [TYPW-1:0] T_RXD  = 3'd1;
  localparam logic [TYPW-1:0] T_TXD  = 3'd2;
  localparam logic [TYPW-1:0] T_RXST = 3'd3;
  localparam logic [TYPW-1:0] T_BRK  = 3'd4;
  localparam logic [TYPW-1:0] T_TMR  = 3'd5;
  localparam logic [TYPW-1:0] T_INP  = 3'd6;

  // transmit level saturates at 3 so its top bit stays zero
  function automatic logic [LVLW-1:0] tx_level(input logic [LVLW-1:0] free);
    return (free >= 3'd3) ? 3'd3 : free;
  endfunction
endpackage

// File: rtl/irq_bid_gen.sv
module irq_bid_gen
  import irq_bid_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NEV  = 2 * NCH + 2,
  localparam int NSRC = 4 * NCH + 2
) (
  input  logic [NCH*LVLW-1:0]  rx_cnt,
  input  logic [NCH*LVLW-1:0]  tx_free,
  input  logic [NEV-1:0]       evt_req,
  input  logic [LVLW-1:0]      evt_lvl,
  input  logic [NSRC-1:0]      mask,
  output logic [NSRC-1:0]      req,
  output logic [NSRC*BIDW-1:0] bid,
  output logic [NSRC*LVLW-1:0] fld,
  output logic [NSRC*CHW-1:0]  chan
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int IRX = ch;
    localparam int ITX = NCH + ch;
    localparam int IST = 2 * NCH + ch;
    localparam int IBK = 3 * NCH + ch;
    logic [LVLW-1:0] rc, tf;
    assign rc = rx_cnt[ch*LVLW +: LVLW];
    assign tf = tx_free[ch*LVLW +: LVLW];

    assign req[IRX] = mask[IRX] && (rc != '0);
    assign bid[IRX*BIDW +: BIDW] = {rc, T_RXD};
    assign fld[IRX*LVLW +: LVLW] = rc;
    assign chan[IRX*CHW +: CHW]  = CHW'(ch);

    assign req[ITX] = mask[ITX] && (tf != '0);
    assign bid[ITX*BIDW +: BIDW] = {tx_level(tf), T_TXD};
    assign fld[ITX*LVLW +: LVLW] = tf;
    assign chan[ITX*CHW +: CHW]  = CHW'(ch);

    assign req[IST] = mask[IST] && evt_req[ch];
    assign bid[IST*BIDW +: BIDW] = {evt_lvl, T_RXST};
    assign fld[IST*LVLW +: LVLW] = evt_lvl;
    assign chan[IST*CHW +: CHW]  = CHW'(ch);

    assign req[IBK] = mask[IBK] && evt_req[NCH+ch];
    assign bid[IBK*BIDW +: BIDW] = {evt_lvl, T_BRK};
    assign fld[IBK*LVLW +: LVLW] = evt_lvl;
    assign chan[IBK*CHW +: CHW]  = CHW'(ch);
  end

  localparam int ITM = 4 * NCH;
  localparam int IIN = 4 * NCH + 1;

  assign req[ITM] = mask[ITM] && evt_req[2*NCH];
  assign bid[ITM*BIDW +: BIDW] = {evt_lvl, T_TMR};
  assign fld[ITM*LVLW +: LVLW] = evt_lvl;
  assign chan[ITM*CHW +: CHW]  = '0;

  assign req[IIN] = mask[IIN] && evt_req[2*NCH+1];
  assign bid[IIN*BIDW +: BIDW] = {evt_lvl, T_INP};
  assign fld[IIN*LVLW +: LVLW] = evt_lvl;
  assign chan[IIN*CHW +: CHW]  = '0;
endmodule

// File: rtl/irq_bid_arb.sv
module irq_bid_arb
  import irq_bid_pkg::*;
#(
  parameter int NSRC = 18,
  parameter int CHW  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      req,
  input  logic [NSRC*BIDW-1:0] bid,
  input  logic [NSRC*LVLW-1:0] fld,
  input  logic [NSRC*CHW-1:0]  chan,
  input  logic [BIDW-1:0]      thr,
  output logic                 found,
  output logic [BIDW-1:0]      w_bid,
  output logic [LVLW-1:0]      w_fld,
  output logic [CHW-1:0]       w_chan
);
  // the threshold is the initial holder; strict compare keeps the lowest index on ties
  always_comb begin
    w_bid  = thr;
    found  = 1'b0;
    w_fld  = '0;
    w_chan = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (bid[i*BIDW +: BIDW] > w_bid)) begin
        w_bid  = bid[i*BIDW +: BIDW];
        found  = 1'b1;
        w_fld  = fld[i*LVLW +: LVLW];
        w_chan = chan[i*CHW +: CHW];
      end
    end
  end

  // R8: a high threshold locks out every transmit bid
  p_tx_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (thr[BIDW-1] && found) |-> (w_bid[TYPW-1:0] != T_TXD));

  // R4: a reported winner is strictly above the threshold
  p_above_thr_r4: assert property (@(posedge clk) disable iff (rst)
    found |-> (w_bid > thr));
endmodule

// File: rtl/irq_cir_reg.sv
module irq_cir_reg
  import irq_bid_pkg::*;
#(
  parameter int CHW = 2,
  localparam int CIRW = LVLW + TYPW + CHW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            found,
  input  logic [TYPW-1:0] w_typ,
  input  logic [LVLW-1:0] w_fld,
  input  logic [CHW-1:0]  w_chan,
  input  logic            capture,
  output logic            irq_n,
  output logic [CIRW-1:0] cir
);
  logic            ev_found;
  logic [TYPW-1:0] ev_typ;
  logic [LVLW-1:0] ev_fld;
  logic [CHW-1:0]  ev_chan;

  // evaluation latch refreshed every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_found <= 1'b0;
      ev_typ   <= '0;
      ev_fld   <= '0;
      ev_chan  <= '0;
      irq_n    <= 1'b1;
    end else begin
      ev_found <= found;
      ev_typ   <= w_typ;
      ev_fld   <= w_fld;
      ev_chan  <= w_chan;
      irq_n    <= ~found;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cir <= '1;
    else if (capture)
      cir <= ev_found ? {ev_fld, ev_typ, ev_chan} : '1;
  end

  // R6: the register moves only after a capture request
  p_cir_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(cir));

  // R5: a capture with no pending interrupt reads as all ones
  p_idle_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (capture && irq_n) |=> (cir == '1));
endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
  import irq_bid_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NEV  = 2 * NCH + 2,
  localparam int NSRC = 4 * NCH + 2,
  localparam int CIRW = LVLW + TYPW + CHW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [NSRC-1:0]     cfg_mask,
  input  logic [BIDW-1:0]     cfg_thr,
  input  logic [LVLW-1:0]     cfg_evt_lvl,
  input  logic [NCH*LVLW-1:0] rx_cnt,
  input  logic [NCH*LVLW-1:0] tx_free,
  input  logic [NEV-1:0]      evt_req,
  input  logic                iack,
  input  logic                cir_upd,
  output logic                irq_n,
  output logic [CIRW-1:0]     cir,
  output logic [LVLW-1:0]     gl_cnt,
  output logic [CHW-1:0]      gl_chan,
  input  logic                gl_rd,
  input  logic                gl_wr,
  output logic [NCH-1:0]      rxh_rd,
  output logic [NCH-1:0]      txh_wr,
  input  logic [NCH*DW-1:0]   rx_hold,
  output logic [DW-1:0]       gl_rx_data
);
  logic [NSRC-1:0]      mask_q;
  logic [BIDW-1:0]      thr_q;
  logic [LVLW-1:0]      lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      thr_q  <= '0;
      lvl_q  <= '0;
    end else if (cfg_we) begin
      mask_q <= cfg_mask;
      thr_q  <= cfg_thr;
      lvl_q  <= cfg_evt_lvl;
    end
  end

  logic [NSRC-1:0]      req;
  logic [NSRC*BIDW-1:0] bid;
  logic [NSRC*LVLW-1:0] fld;
  logic [NSRC*CHW-1:0]  chan;

  irq_bid_gen #(.NCH(NCH)) u_gen (
    .rx_cnt(rx_cnt), .tx_free(tx_free), .evt_req(evt_req), .evt_lvl(lvl_q),
    .mask(mask_q), .req(req), .bid(bid), .fld(fld), .chan(chan)
  );

  logic            found;
  logic [BIDW-1:0] w_bid;
  logic [LVLW-1:0] w_fld;
  logic [CHW-1:0]  w_chan;

  irq_bid_arb #(.NSRC(NSRC), .CHW(CHW)) u_arb (
    .clk(clk), .rst(rst), .req(req), .bid(bid), .fld(fld), .chan(chan),
    .thr(thr_q), .found(found), .w_bid(w_bid), .w_fld(w_fld), .w_chan(w_chan)
  );

  irq_cir_reg #(.CHW(CHW)) u_cir (
    .clk(clk), .rst(rst), .found(found), .w_typ(w_bid[TYPW-1:0]),
    .w_fld(w_fld), .w_chan(w_chan), .capture(iack | cir_upd),
    .irq_n(irq_n), .cir(cir)
  );

  assign gl_cnt  = cir[CIRW-1 -: LVLW];
  assign gl_chan = cir[CHW-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_steer
    assign rxh_rd[ch] = gl_rd && (gl_chan == CHW'(ch));
    assign txh_wr[ch] = gl_wr && (gl_chan == CHW'(ch));
  end

  always_comb begin
    gl_rx_data = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (gl_chan == CHW'(ch)) gl_rx_data = rx_hold[ch*DW +: DW];
  end

  // R10: at most one channel strobe at a time
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rxh_rd) && $onehot0(txh_wr));

  // R2: with every source masked off, no interrupt follows
  p_all_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> irq_n);
endmodule

// File: tb/tb_irq_bid_arbiter.sv
`timescale 1ns/1ps
module tb_irq_bid_arbiter;
  localparam int NCH = 4;
  localparam int NSRC = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [NSRC-1:0] cfg_mask = '0;
  logic [5:0] cfg_thr = '0;
  logic [2:0] cfg_evt_lvl = '0;
  logic [11:0] rx_cnt = '0, tx_free = '0;
  logic [9:0] evt_req = '0;
  logic iack = 1'b0, cir_upd = 1'b0, gl_rd = 1'b0, gl_wr = 1'b0;
  logic [31:0] rx_hold = 32'h44_33_22_11;
  logic irq_n;
  logic [7:0] cir, gl_rx_data;
  logic [2:0] gl_cnt;
  logic [1:0] gl_chan;
  logic [3:0] rxh_rd, txh_wr;

  irq_bid_arbiter dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_thr(cfg_thr),
    .cfg_evt_lvl(cfg_evt_lvl), .rx_cnt(rx_cnt), .tx_free(tx_free), .evt_req(evt_req),
    .iack(iack), .cir_upd(cir_upd), .irq_n(irq_n), .cir(cir), .gl_cnt(gl_cnt),
    .gl_chan(gl_chan), .gl_rd(gl_rd), .gl_wr(gl_wr), .rxh_rd(rxh_rd), .txh_wr(txh_wr),
    .rx_hold(rx_hold), .gl_rx_data(gl_rx_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit mon_en = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit [NSRC-1:0] m_mask;
  int m_thr, m_lvl;
  bit m_found, m_irq_n;
  int m_typ, m_fld, m_chan;
  bit [7:0] m_cir;

  task automatic src_info(input int s, output int v, output int f, output int t,
                          output int c, output bit act);
    int n;
    if (s < 4) begin
      n = int'(rx_cnt[s*3 +: 3]); t = 1; f = n; v = n * 8 + t; c = s; act = (n != 0);
    end else if (s < 8) begin
      n = int'(tx_free[(s-4)*3 +: 3]); t = 2; f = n; v = ((n > 3) ? 3 : n) * 8 + t;
      c = s - 4; act = (n != 0);
    end else if (s < 16) begin
      t = (s < 12) ? 3 : 4; f = m_lvl; v = m_lvl * 8 + t; c = s % 4; act = evt_req[s-8];
    end else begin
      t = (s == 16) ? 5 : 6; f = m_lvl; v = m_lvl * 8 + t; c = 0; act = evt_req[s-8];
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mask = '0; m_thr = 0; m_lvl = 0; m_found = 0; m_irq_n = 1; m_cir = 8'hFF;
      m_typ = 0; m_fld = 0; m_chan = 0;
    end else begin
      int best, v, f, t, c;
      bit a, done;
      if (iack || cir_upd)
        m_cir = m_found ? 8'((m_fld << 5) | (m_typ << 2) | m_chan) : 8'hFF;
      best = -1;
      for (int s = 0; s < NSRC; s++) begin
        src_info(s, v, f, t, c, a);
        if (a && m_mask[s] && v > m_thr && v > best) best = v;
      end
      m_found = (best >= 0);
      m_irq_n = !m_found;
      done = 0;
      for (int s = 0; s < NSRC; s++) begin
        src_info(s, v, f, t, c, a);
        if (!done && a && m_mask[s] && v == best && m_found) begin
          m_typ = t; m_fld = f; m_chan = c; done = 1;
        end
      end
      if (cfg_we) begin
        m_mask = cfg_mask; m_thr = int'(cfg_thr); m_lvl = int'(cfg_evt_lvl);
      end
    end
  end

  // per-cycle comparison away from the clock edge
  always begin
    @(negedge clk); #2;
    if (mon_en) begin
      chk("R3 irq_n model", irq_n, m_irq_n);
      chk("R6 cir model", cir, m_cir);
      chk("R10 steering model",
          {gl_cnt, gl_chan, rxh_rd, txh_wr, gl_rx_data},
          {m_cir[7:5], m_cir[1:0], gl_rd ? 4'(1 << m_cir[1:0]) : 4'd0,
           gl_wr ? 4'(1 << m_cir[1:0]) : 4'd0, rx_hold[m_cir[1:0]*8 +: 8]});
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic cfg(logic [NSRC-1:0] mk, logic [5:0] th, logic [2:0] lv);
    cfg_we = 1; cfg_mask = mk; cfg_thr = th; cfg_evt_lvl = lv;
    run(1);
    cfg_we = 0;
  endtask

  task automatic grab(bit use_upd);
    if (use_upd) cir_upd = 1; else iack = 1;
    run(1);
    iack = 0; cir_upd = 0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rx_cnt[2*3 +: 3] = 3'd3;
    run(3);
    rst = 0;
    mon_en = 1;
    run(2);
    chk("R1 irq_n after reset", irq_n, 1);
    chk("R1 cir after reset", cir, 8'hFF);

    cfg('1, 6'd0, 3'd0);
    run(2);
    chk("R3 rx ch2 raises irq", irq_n, 0);
    grab(0);
    chk("R7 cir rx ch2 count 3", cir, 8'h66);
    chk("R7 gl_cnt", gl_cnt, 3);

    cfg(~18'h4, 6'd0, 3'd0);
    run(2);
    chk("R2 masked rx ch2", irq_n, 1);
    grab(1);
    chk("R5 update while idle", cir, 8'hFF);

    cfg('1, 6'd17, 3'd0);
    rx_cnt = '0; rx_cnt[1*3 +: 3] = 3'd2;
    run(2);
    chk("R4 bid equal to threshold", irq_n, 1);
    cfg('1, 6'd16, 3'd0);
    run(2);
    chk("R4 bid above threshold", irq_n, 0);

    cfg('1, 6'd32, 3'd0);
    rx_cnt = '0; tx_free[0 +: 3] = 3'd7;
    run(2);
    chk("R8 tx blocked by high threshold", irq_n, 1);
    rx_cnt[3*3 +: 3] = 3'd4;
    run(2);
    chk("R8 rx 4 bytes beats threshold", irq_n, 0);
    cfg('1, 6'd0, 3'd0);
    run(2);
    grab(0);
    chk("R8 rx outranks full tx", cir, 8'h87);

    tx_free = '0; rx_cnt = '0;
    rx_cnt[1*3 +: 3] = 3'd5; rx_cnt[3*3 +: 3] = 3'd5;
    run(2);
    grab(0);
    chk("R9 tie goes to lower index", cir, 8'hA5);

    rx_cnt[0 +: 3] = 3'd7;
    run(3);
    chk("R6 cir holds without capture", cir, 8'hA5);
    chk("R6 irq still low", irq_n, 0);

    rx_cnt = '0;
    cfg('1, 6'd0, 3'd6);
    evt_req[2] = 1;
    run(2);
    grab(0);
    chk("R7 status field is level", cir, 8'hCE);
    chk("R7 gl_cnt non-data", gl_cnt, 6);
    evt_req[5] = 1;
    run(2);
    grab(1);
    chk("R6 update loads break ch1", cir, 8'hD1);

    gl_rd = 1; gl_wr = 1;
    #1;
    chk("R10 read strobe ch1", rxh_rd, 4'b0010);
    chk("R10 write strobe ch1", txh_wr, 4'b0010);
    chk("R10 read data ch1", gl_rx_data, 8'h22);
    chk("R10 global channel", gl_chan, 1);
    run(2);
    gl_rd = 0; gl_wr = 0;
    evt_req = '0;
    run(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule